// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the host side of a byte-wide flash array and watches the write cycles that the host issues. Each write carries an address and a data byte. The block recognises the multi-write command sequences that the array understands and turns each complete sequence into a single-cycle operation pulse. Five operations are decoded: read/reset, identification (autoselect) mode entry, byte program, whole-array erase and sector erase.

Every command except read/reset begins with a two-write unlock to fixed addresses, followed by a command byte. The erase commands add a setup byte and a second unlock before the final byte. Any write that does not fit the expected step abandons the sequence and returns the decoder to read mode without issuing anything. A supply-low lockout input forces read mode and blocks all writes. The address and data of the write that completed a sequence are held on the outputs until the next operation is issued.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode (`mode_id`=0) and issues no pulse; a write strobe that is already active when reset is released is not counted until it goes inactive and active again.
- R2: A write of F0h to any address issues one `op_reset` pulse and leaves the decoder in read mode, at any sequence step except the program-data step.
- R3: Writes AAh@5555h, 55h@2AAAh, 90h@5555h issue one `op_autosel` pulse and set `mode_id` to 1 in the same cycle.
- R4: Writes AAh@5555h, 55h@2AAAh, A0h@5555h, then any write, issue one `op_program` pulse with `op_addr`/`op_data` equal to that fourth write's address and data, even when the data is F0h.
- R5: Writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h issue one `op_chip_erase` pulse.
- R6: The same five-write prefix followed by 30h at any address issues one `op_sector_erase` pulse with `op_addr` equal to that full 19-bit address.
- R7: Unlock and command addresses are matched on address bits 14..0 only; bits 18..15 are ignored for matching.
- R8: A write counts only while `bus_cs`=1, `bus_we`=1 and `bus_oe`=0, and counts once per assertion of that condition however many cycles it lasts.
- R9: While `vcc_low`=1 the decoder returns to read mode, drops any partial sequence and ignores writes; no pulse is issued.
- R10: A write that does not match the expected step aborts the sequence with no pulse and clears `mode_id`; a following correct sequence is decoded normally.
- R11: An operation pulse follows the completing write by one clock; `op_addr` and `op_data` change only in a cycle that carries a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Chip select, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_oe | input | 1 | Output enable, active high (blocks writes) |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | 8 | Write data |
| vcc_low | input | 1 | Supply-low lockout |
| op_reset | output | 1 | Read/reset pulse |
| op_autosel | output | 1 | Autoselect entry pulse |
| op_program | output | 1 | Byte program pulse |
| op_chip_erase | output | 1 | Whole-array erase pulse |
| op_sector_erase | output | 1 | Sector erase pulse |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | 8 | Data of the completing write |
| mode_id | output | 1 | 1 while in autoselect mode |

## Verification
The bench builds the decoder with its defaults, a 19-bit address and a 15-bit match field, so the ignored upper bits 18..15 are real and can be set on unlock writes while still being carried into program and sector targets. Every bench write holds the strobe for two clocks, so a decoder that counted a held strobe twice would abort every sequence. The width split between matched and carried bits is what makes R7 and R6 separable in the checks.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RESET   = 8'hF0;
  localparam logic [BYTE_W-1:0] CMD_UNLK1   = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_UNLK2   = 8'h55;
  localparam logic [BYTE_W-1:0] CMD_AUTOSEL = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_PROG    = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_SETUP   = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_CHIP    = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_SECT    = 8'h30;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3
  } seq_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESET, OP_AUTOSEL, OP_PROG, OP_CHIP, OP_SECT
  } op_e;
endpackage

// File: rtl/fcd_wr_edge.sv
module fcd_wr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic we,
  input  logic oe,
  input  logic lock,
  output logic wr_hit
);
  logic lvl;
  logic prev_q;
  logic prev_d;

  assign lvl    = cs & we & ~oe;
  assign wr_hit = lvl & ~prev_q & ~lock;
  assign prev_d = lvl;

  // prev resets high so a strobe held across reset release is not a new write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
  parameter int MATCH_W = 15,
  parameter int NKEYS   = 2,
  parameter logic [NKEYS*MATCH_W-1:0] KEYS = {15'h2AAA, 15'h5555}
) (
  input  logic [MATCH_W-1:0] addr,
  output logic [NKEYS-1:0]   hit
);
  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign hit[k] = (addr == KEYS[k*MATCH_W +: MATCH_W]);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_hit,
  input  logic              at_a,
  input  logic              at_b,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              mode_q
);
  seq_e              st_q, st_d;
  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BYTE_W-1:0] data_d;
  logic              mode_d;

  always_comb begin
    st_d   = st_q;
    op_d   = OP_NONE;
    addr_d = addr_q;
    data_d = data_q;
    mode_d = mode_q;
    if (lock) begin
      st_d   = S_IDLE;
      mode_d = 1'b0;
    end else if (wr_hit) begin
      st_d = S_IDLE;
      if (st_q == S_PROG) begin
        op_d = OP_PROG;
      end else if (wr_data == CMD_RESET) begin
        op_d = OP_RESET;
      end else begin
        case (st_q)
          S_IDLE: if (at_a && wr_data == CMD_UNLK1) st_d = S_U1;
          S_U1:   if (at_b && wr_data == CMD_UNLK2) st_d = S_U2;
          S_U2: begin
            if (at_a) begin
              if (wr_data == CMD_AUTOSEL)   op_d = OP_AUTOSEL;
              else if (wr_data == CMD_PROG)  st_d = S_PROG;
              else if (wr_data == CMD_SETUP) st_d = S_E1;
            end
          end
          S_E1:   if (at_a && wr_data == CMD_UNLK1) st_d = S_E2;
          S_E2:   if (at_b && wr_data == CMD_UNLK2) st_d = S_E3;
          S_E3: begin
            if (at_a && wr_data == CMD_CHIP) op_d = OP_CHIP;
            else if (wr_data == CMD_SECT)    op_d = OP_SECT;
          end
          default: st_d = S_IDLE;
        endcase
      end
      if (op_d != OP_NONE) begin
        addr_d = wr_addr;
        data_d = wr_data;
      end
      if (op_d == OP_AUTOSEL)                     mode_d = 1'b1;
      else if (op_d != OP_NONE || st_d == S_IDLE) mode_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int MATCH_W = 15,
  parameter logic [MATCH_W-1:0] UNLK_ADDR_A = 15'h5555,
  parameter logic [MATCH_W-1:0] UNLK_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_oe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              vcc_low,
  output logic              op_reset,
  output logic              op_autosel,
  output logic              op_program,
  output logic              op_chip_erase,
  output logic              op_sector_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_data,
  output logic              mode_id
);
  localparam int NKEYS = 2;

  logic             wr_hit;
  logic [NKEYS-1:0] key_hit;
  op_e              op_q;

  fcd_wr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (bus_cs),
    .we     (bus_we),
    .oe     (bus_oe),
    .lock   (vcc_low),
    .wr_hit (wr_hit)
  );

  fcd_addr_match #(
    .MATCH_W (MATCH_W),
    .NKEYS   (NKEYS),
    .KEYS    ({UNLK_ADDR_B, UNLK_ADDR_A})
  ) u_match (
    .addr (bus_addr[MATCH_W-1:0]),
    .hit  (key_hit)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock    (vcc_low),
    .wr_hit  (wr_hit),
    .at_a    (key_hit[0]),
    .at_b    (key_hit[1]),
    .wr_addr (bus_addr),
    .wr_data (bus_data),
    .op_q    (op_q),
    .addr_q  (op_addr),
    .data_q  (op_data),
    .mode_q  (mode_id)
  );

  assign op_reset        = (op_q == OP_RESET);
  assign op_autosel      = (op_q == OP_AUTOSEL);
  assign op_program      = (op_q == OP_PROG);
  assign op_chip_erase   = (op_q == OP_CHIP);
  assign op_sector_erase = (op_q == OP_SECT);
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic              bus_oe,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_data,
  input logic              vcc_low,
  input logic              op_reset,
  input logic              op_autosel,
  input logic              op_program,
  input logic              op_chip_erase,
  input logic              op_sector_erase,
  input logic [ADDR_W-1:0] op_addr,
  input logic [7:0]        op_data,
  input logic              mode_id
);
  logic any_op;
  assign any_op = op_reset | op_autosel | op_program | op_chip_erase | op_sector_erase;

  a_r11_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |-> ($stable(op_addr) && $stable(op_data)));

  a_r4_prog_target: assert property (@(posedge clk) disable iff (!rst_n)
    op_program |-> (op_addr == $past(bus_addr) && op_data == $past(bus_data)));

  a_r8_no_write_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_cs && bus_we && !bus_oe) |=> !any_op);

  a_r9_lock_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_low |=> (!any_op && !mode_id));

  a_r3_mode_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_id) |-> op_autosel);

  a_r2_reset_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
    op_reset |-> !mode_id);
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_cs          (bus_cs),
  .bus_we          (bus_we),
  .bus_oe          (bus_oe),
  .bus_addr        (bus_addr),
  .bus_data        (bus_data),
  .vcc_low         (vcc_low),
  .op_reset        (op_reset),
  .op_autosel      (op_autosel),
  .op_program      (op_program),
  .op_chip_erase   (op_chip_erase),
  .op_sector_erase (op_sector_erase),
  .op_addr         (op_addr),
  .op_data         (op_data),
  .mode_id         (mode_id)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 19;

  logic              clk;
  logic              rst_n;
  logic              bus_cs, bus_we, bus_oe, vcc_low;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_data;
  logic              op_reset, op_autosel, op_program, op_chip_erase, op_sector_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data;
  logic              mode_id;

  int checks = 0;
  int errors = 0;
  int n_rst = 0, n_as = 0, n_pg = 0, n_ce = 0, n_se = 0;
  int b_rst, b_as, b_pg, b_ce, b_se;
  logic [ADDR_W-1:0] last_addr;
  logic [7:0]        last_data;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .bus_data(bus_data), .vcc_low(vcc_low),
    .op_reset(op_reset), .op_autosel(op_autosel), .op_program(op_program),
    .op_chip_erase(op_chip_erase), .op_sector_erase(op_sector_erase),
    .op_addr(op_addr), .op_data(op_data), .mode_id(mode_id)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // pulses last one cycle, so each one is seen at exactly one falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (op_reset)        n_rst++;
      if (op_autosel)      n_as++;
      if (op_program)      n_pg++;
      if (op_chip_erase)   n_ce++;
      if (op_sector_erase) n_se++;
      if (op_reset | op_autosel | op_program | op_chip_erase | op_sector_erase) begin
        last_addr = op_addr;
        last_data = op_data;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic snap();
    b_rst = n_rst; b_as = n_as; b_pg = n_pg; b_ce = n_ce; b_se = n_se;
  endtask

  task automatic expect_ops(input string req, input int r, input int a, input int p,
                            input int c, input int s);
    chk({req, " reset count"},    n_rst - b_rst, r);
    chk({req, " autosel count"},  n_as - b_as, a);
    chk({req, " program count"},  n_pg - b_pg, p);
    chk({req, " chip count"},     n_ce - b_ce, c);
    chk({req, " sector count"},   n_se - b_se, s);
  endtask

  task automatic wr_full(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input logic cs, input logic oe, input int hold);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_cs = cs; bus_we = 1'b1; bus_oe = oe;
    repeat (hold) @(negedge clk);
    bus_we = 1'b0; bus_cs = 1'b0; bus_oe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_full(a, d, 1'b1, 1'b0, 2);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic t_reset_state();
    // R1: strobe held with F0h across reset release is not a write
    bus_cs = 1'b1; bus_we = 1'b1; bus_oe = 1'b0; bus_addr = 19'h00123; bus_data = 8'hF0;
    rst_n = 1'b0; vcc_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    snap();
    repeat (4) @(negedge clk);
    chk("R1 mode after reset", mode_id, 0);
    expect_ops("R1 held strobe", 0, 0, 0, 0, 0);
    bus_we = 1'b0; bus_cs = 1'b0;
    @(negedge clk);
    wr(19'h00123, 8'hF0);
    expect_ops("R1 fresh strobe", 1, 0, 0, 0, 0);
  endtask

  task automatic t_autosel();
    snap();
    unlock(); wr(19'h05555, 8'h90);
    expect_ops("R3 autosel", 0, 1, 0, 0, 0);
    chk("R3 mode set", mode_id, 1);
  endtask

  task automatic t_read_reset();
    // R2: F0h mid-sequence at an arbitrary address
    snap();
    wr(19'h05555, 8'hAA);
    wr(19'h4ABCD, 8'hF0);
    expect_ops("R2 reset mid sequence", 1, 0, 0, 0, 0);
    chk("R2 mode cleared", mode_id, 0);
    chk("R2 target latched", last_addr, 19'h4ABCD);
  endtask

  task automatic t_program();
    snap();
    unlock(); wr(19'h05555, 8'hA0); wr(19'h71234, 8'h3C);
    expect_ops("R4 program", 0, 0, 1, 0, 0);
    chk("R4 program addr", last_addr, 19'h71234);
    chk("R4 program data", last_data, 8'h3C);
    chk("R11 op_addr held", op_addr, 19'h71234);
    snap();
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00042, 8'hF0);
    expect_ops("R4 program F0 data", 0, 0, 1, 0, 0);
    chk("R4 program F0 value", last_data, 8'hF0);
  endtask

  task automatic t_chip();
    snap();
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h10);
    expect_ops("R5 chip erase", 0, 0, 0, 1, 0);
    snap();
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h01234, 8'h10);
    expect_ops("R10 chip byte off address", 0, 0, 0, 0, 0);
  endtask

  task automatic t_sector();
    snap();
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h53210, 8'h30);
    expect_ops("R6 sector erase", 0, 0, 0, 0, 1);
    chk("R6 sector addr", last_addr, 19'h53210);
  endtask

  task automatic t_upper_bits();
    snap();
    wr(19'h7D555, 8'hAA); wr(19'h1AAAA, 8'h55); wr(19'h4D555, 8'h90);
    expect_ops("R7 upper bits ignored", 0, 1, 0, 0, 0);
    snap();
    wr(19'h05554, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
    expect_ops("R7 low bit mismatch", 0, 0, 0, 0, 0);
    chk("R10 mode cleared by abort", mode_id, 0);
  endtask

  task automatic t_qualify();
    snap();
    unlock();
    wr_full(19'h05555, 8'h90, 1'b0, 1'b0, 2);   // no chip select
    wr_full(19'h05555, 8'h90, 1'b1, 1'b1, 2);   // output enable active
    wr(19'h05555, 8'h90);
    expect_ops("R8 unqualified ignored", 0, 1, 0, 0, 0);
    snap();
    wr_full(19'h05555, 8'hAA, 1'b1, 1'b0, 7);   // long strobe counts once
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00077, 8'h5A);
    expect_ops("R8 long strobe", 0, 0, 1, 0, 0);
  endtask

  task automatic t_lockout();
    snap();
    unlock(); wr(19'h05555, 8'h90);
    chk("R9 mode before lock", mode_id, 1);
    @(negedge clk); vcc_low = 1'b1;
    @(negedge clk);
    chk("R9 lock clears mode", mode_id, 0);
    vcc_low = 1'b0;
    snap();
    unlock();
    vcc_low = 1'b1;
    wr(19'h05555, 8'h90);
    wr(19'h00000, 8'hF0);
    vcc_low = 1'b0;
    wr(19'h05555, 8'h90);
    expect_ops("R9 locked writes ignored", 0, 0, 0, 0, 0);
  endtask

  task automatic t_abort();
    snap();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h56);
    wr(19'h05555, 8'h90);
    expect_ops("R10 wrong data aborts", 0, 0, 0, 0, 0);
    unlock(); wr(19'h05555, 8'h90);
    expect_ops("R10 recovery", 0, 1, 0, 0, 0);
  endtask

  initial begin
    bus_cs = 1'b0; bus_we = 1'b0; bus_oe = 1'b0; vcc_low = 1'b0;
    bus_addr = '0; bus_data = '0; rst_n = 1'b0;
    t_reset_state();
    t_autosel();
    t_read_reset();
    t_program();
    t_chip();
    t_sector();
    t_upper_bits();
    t_qualify();
    t_lockout();
    t_abort();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule